// File: doc/BRIEF.md
# Instruction Address Compare Tagger

This block watches the instruction fetch stream for addresses that a debugger has loaded into a set of instruction address comparators. Each fetch delivers one aligned word holding two halfwords. Both halfwords are compared against every comparator in the same cycle. The match bits are stored as tags beside the buffered word, so each halfword keeps its own hit record while it waits for decode.

A small decode-side state machine walks the buffered halfwords one instruction at a time. Decode supplies the length of the instruction that starts at the current halfword. An instruction issues from its first halfword. If that halfword carries an enabled hit, a debug event pulse is raised together with the number of the comparator that caused it, and that comparator's sticky status bit is set. The trailing halfword of a 32-bit instruction is passed over, so a hit on that halfword alone never raises an event.

The machine has four states:
- ALIGN: no position known. It is entered after reset and after a flush.
- LO: the next instruction starts at the low halfword.
- HI: the next instruction starts at the high halfword.
- SPILL: a 32-bit instruction began on a high halfword, so the low halfword of the next word is its tail.

The transitions are:
- ALIGN to LO or HI when a word is accepted, chosen by the halfword select bit of the fetch address.
- LO to LO after a 32-bit issue.
- LO to HI after a 16-bit issue.
- HI to LO after a 16-bit issue.
- HI to SPILL after a 32-bit issue.
- SPILL to HI once the next word is buffered.
- Any state to ALIGN on flush.

Top module: `iac_tagger`

## Requirements
- R1: `fetch_addr` is a halfword address (byte address bits 31..1). The low halfword of a fetch has `fetch_addr` bit 1 forced to 0, and the high halfword has it forced to 1. Tag bit i of a halfword is 1 exactly when that halfword's bits 31..1 equal bits 31..1 of comparator i. Bit 0 of the comparator is ignored.
- R2: A word is accepted when `fetch_valid` and `fetch_ready` are both 1 at a clock edge. Its tags appear on `tag_lo`/`tag_hi`, with `tag_valid` set to 1, after that edge. They stay unchanged until the word is consumed. After reset, `tag_valid`, `evt_valid` and `evt_status` are 0.
- R3: When an instruction issues from a halfword whose tags, ANDed with `cmp_en`, are nonzero, `evt_valid` is 1 for one cycle after the issuing edge. A 16-bit instruction issues from its only halfword. A 32-bit instruction (`dec_is32`=1) issues from its first halfword.
- R4: A hit on the second halfword of a 32-bit instruction alone, whether in the same word or in the next word, raises no event.
- R5: While `dec_block` is 1, the instruction at the current position does not issue, raises no event and stays in place.
- R6: A comparator whose `cmp_en` bit is 0 raises no event and does not set its status bit.
- R7: When several enabled comparators hit, `evt_id` gives the lowest-numbered one.
- R8: Bit i of `evt_status` is set when comparator i causes an issue-time hit. It is cleared by writing 1 to bit i of `stat_clr`. A set in the same cycle wins over a clear.
- R9: `flush` discards the buffered word, the word offered in the same cycle, and any issue in that cycle. After it, `tag_valid` is 0.
- R10: After reset or a flush, the first accepted word starts at the halfword selected by `fetch_addr` bit 1.
- R11: `fetch_ready` is 1 when no word is buffered, or when the buffered word is consumed this cycle. A word is consumed by a 16-bit or 32-bit issue from the high halfword, or by a 32-bit issue from the low halfword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | Fetch word offered |
| fetch_addr | input | ADDR_W-1 | Halfword address of the fetch (bits 31..1); bit 1 selects the start halfword after realignment |
| fetch_ready | output | 1 | Word can be accepted this cycle |
| flush | input | 1 | Discard buffered word and realign |
| dec_is32 | input | 1 | Instruction at the current halfword is 32 bits long |
| dec_block | input | 1 | Higher-priority exception at this boundary; suppress issue |
| cmp_addr | input | NUM_CMP*ADDR_W | Comparator byte addresses, comparator i in slice i |
| cmp_en | input | NUM_CMP | Per-comparator event enable |
| stat_clr | input | NUM_CMP | Write-one-to-clear for the status bits |
| tag_valid | output | 1 | A tagged word is buffered |
| tag_lo | output | NUM_CMP | Hit tags of the low halfword |
| tag_hi | output | NUM_CMP | Hit tags of the high halfword |
| evt_valid | output | 1 | Debug event pulse |
| evt_id | output | ID_W | Comparator that caused the event |
| evt_status | output | NUM_CMP | Sticky per-comparator hit status |

## Verification
Some properties are checked by assertions on every cycle:
- A raised event always has its comparator's status bit set.
- A blocked boundary or a SPILL position never yields an event.
- Buffered tags hold steady while the word waits.
- A flush always empties the buffer.

Other behaviour can only be shown by the bench's scenarios. These are the ignored address bit 0, tail-halfword hits in both the same word and the next word, the start position after realignment, lowest-index selection, and set-over-clear on the status. The bench checks them against a reference model driven by both directed and seeded random streams.

// File: rtl/iact_pkg.sv
package iact_pkg;

    typedef enum logic [1:0] {
        ST_ALIGN = 2'd0,
        ST_LO    = 2'd1,
        ST_HI    = 2'd2,
        ST_SPILL = 2'd3
    } iact_state_e;

endpackage

// File: rtl/iact_compare.sv
module iact_compare #(
    parameter int ADDR_W  = 32,
    parameter int NUM_CMP = 2
) (
    input  logic [ADDR_W-1:1]         fetch_addr,
    input  logic [NUM_CMP*ADDR_W-1:0] cmp_addr,
    output logic [NUM_CMP-1:0]        hit_lo,
    output logic [NUM_CMP-1:0]        hit_hi
);
    localparam int HW_W = ADDR_W - 1;

    logic [HW_W-1:0] hw_lo;
    logic [HW_W-1:0] hw_hi;

    // R1: both halfwords of the word are formed and compared together
    assign hw_lo = {fetch_addr[ADDR_W-1:2], 1'b0};
    assign hw_hi = {fetch_addr[ADDR_W-1:2], 1'b1};

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        logic [ADDR_W-1:0] ref_addr;
        assign ref_addr = cmp_addr[i*ADDR_W +: ADDR_W];
        // bit 0 of the comparator is copied in, so it never affects the result
        assign hit_lo[i] = ({hw_lo, ref_addr[0]} == ref_addr);
        assign hit_hi[i] = ({hw_hi, ref_addr[0]} == ref_addr);
    end

endmodule

// File: rtl/iact_tag_stage.sv
module iact_tag_stage #(
    parameter int NUM_CMP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               load,
    input  logic               drop,
    input  logic [NUM_CMP-1:0] lo_in,
    input  logic [NUM_CMP-1:0] hi_in,
    output logic               buf_v,
    output logic [NUM_CMP-1:0] tag_lo,
    output logic [NUM_CMP-1:0] tag_hi
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_v  <= 1'b0;
            tag_lo <= '0;
            tag_hi <= '0;
        end else if (flush) begin
            buf_v  <= 1'b0;
        end else if (load) begin
            buf_v  <= 1'b1;
            tag_lo <= lo_in;
            tag_hi <= hi_in;
        end else if (drop) begin
            buf_v  <= 1'b0;
        end
    end

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !buf_v);

    a_r2_tags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_v && !load && !drop && !flush) |=> (buf_v && $stable(tag_lo) && $stable(tag_hi)));

    a_r2_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flush) |=> buf_v);

endmodule

// File: rtl/iact_issue_fsm.sv
module iact_issue_fsm
    import iact_pkg::*;
#(
    parameter int NUM_CMP = 2,
    parameter int ID_W    = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               fetch_valid,
    input  logic               fetch_hi,
    input  logic               buf_v,
    input  logic [NUM_CMP-1:0] tag_lo,
    input  logic [NUM_CMP-1:0] tag_hi,
    input  logic               dec_is32,
    input  logic               dec_block,
    input  logic [NUM_CMP-1:0] cmp_en,
    input  logic [NUM_CMP-1:0] stat_clr,
    output logic               fetch_ready,
    output logic               load,
    output logic               consume,
    output logic               evt_valid,
    output logic [ID_W-1:0]    evt_id,
    output logic [NUM_CMP-1:0] evt_status
);

    iact_state_e state, state_nx;

    logic               issue;
    logic [NUM_CMP-1:0] start_tag;
    logic [NUM_CMP-1:0] hits;
    logic [ID_W-1:0]    first_id;

    // R5, R9: issue needs a buffered word at a start position, no block, no flush
    assign issue     = buf_v && !flush && !dec_block &&
                       ((state == ST_LO) || (state == ST_HI));
    // R11: the word leaves when its last halfword is used
    assign consume   = issue && ((state == ST_HI) || dec_is32);
    assign fetch_ready = !buf_v || consume;
    assign load      = fetch_valid && fetch_ready;

    // R3, R4: only the start halfword's tags are looked at
    assign start_tag = (state == ST_HI) ? tag_hi : tag_lo;
    assign hits      = start_tag & cmp_en;   // R6

    // R7: lowest-numbered hit wins
    always_comb begin
        first_id = '0;
        for (int i = NUM_CMP - 1; i >= 0; i--) begin
            if (hits[i]) first_id = ID_W'(i);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ALIGN: if (load)  state_nx = fetch_hi ? ST_HI : ST_LO;   // R10
            ST_LO:    if (issue) state_nx = dec_is32 ? ST_LO : ST_HI;
            ST_HI:    if (issue) state_nx = dec_is32 ? ST_SPILL : ST_LO;
            ST_SPILL: if (buf_v) state_nx = ST_HI;                      // R4
            default:             state_nx = ST_ALIGN;
        endcase
        if (flush) state_nx = ST_ALIGN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ALIGN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid  <= 1'b0;
            evt_id     <= '0;
            evt_status <= '0;
        end else begin
            evt_valid  <= issue && (|hits);
            if (issue && (|hits)) evt_id <= first_id;
            // R8: set wins over clear
            evt_status <= (evt_status & ~stat_clr) | (issue ? hits : '0);
        end
    end

    a_r8_event_marks_status: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_status[evt_id]);

    a_r5_block_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        dec_block |=> !evt_valid);

    a_r4_tail_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPILL) |=> !evt_valid);

    a_r9_flush_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !evt_valid);

endmodule

// File: rtl/iac_tagger.sv
module iac_tagger #(
    parameter int ADDR_W  = 32,
    parameter int NUM_CMP = 2,
    parameter int ID_W    = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fetch_valid,
    input  logic [ADDR_W-1:1]         fetch_addr,
    output logic                      fetch_ready,
    input  logic                      flush,
    input  logic                      dec_is32,
    input  logic                      dec_block,
    input  logic [NUM_CMP*ADDR_W-1:0] cmp_addr,
    input  logic [NUM_CMP-1:0]        cmp_en,
    input  logic [NUM_CMP-1:0]        stat_clr,
    output logic                      tag_valid,
    output logic [NUM_CMP-1:0]        tag_lo,
    output logic [NUM_CMP-1:0]        tag_hi,
    output logic                      evt_valid,
    output logic [ID_W-1:0]           evt_id,
    output logic [NUM_CMP-1:0]        evt_status
);

    logic [NUM_CMP-1:0] hit_lo;
    logic [NUM_CMP-1:0] hit_hi;
    logic               load;
    logic               consume;

    iact_compare #(
        .ADDR_W  (ADDR_W),
        .NUM_CMP (NUM_CMP)
    ) u_cmp (
        .fetch_addr (fetch_addr),
        .cmp_addr   (cmp_addr),
        .hit_lo     (hit_lo),
        .hit_hi     (hit_hi)
    );

    iact_tag_stage #(
        .NUM_CMP (NUM_CMP)
    ) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .load   (load),
        .drop   (consume),
        .lo_in  (hit_lo),
        .hi_in  (hit_hi),
        .buf_v  (tag_valid),
        .tag_lo (tag_lo),
        .tag_hi (tag_hi)
    );

    iact_issue_fsm #(
        .NUM_CMP (NUM_CMP),
        .ID_W    (ID_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .fetch_valid (fetch_valid),
        .fetch_hi    (fetch_addr[1]),
        .buf_v       (tag_valid),
        .tag_lo      (tag_lo),
        .tag_hi      (tag_hi),
        .dec_is32    (dec_is32),
        .dec_block   (dec_block),
        .cmp_en      (cmp_en),
        .stat_clr    (stat_clr),
        .fetch_ready (fetch_ready),
        .load        (load),
        .consume     (consume),
        .evt_valid   (evt_valid),
        .evt_id      (evt_id),
        .evt_status  (evt_status)
    );

endmodule

// File: tb/iac_tagger_tb.sv
module iac_tagger_tb;

    localparam int AW = 32;
    localparam int NC = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           fetch_valid = 1'b0;
    logic [AW-1:1]  fetch_addr = '0;
    logic           fetch_ready;
    logic           flush = 1'b0;
    logic           dec_is32 = 1'b0;
    logic           dec_block = 1'b0;
    logic [NC*AW-1:0] cmp_addr = '0;
    logic [NC-1:0]  cmp_en = '0;
    logic [NC-1:0]  stat_clr = '0;
    logic           tag_valid;
    logic [NC-1:0]  tag_lo, tag_hi;
    logic           evt_valid;
    logic [0:0]     evt_id;
    logic [NC-1:0]  evt_status;

    int checks = 0;
    int fails  = 0;

    // reference model state: 0 align, 1 lo, 2 hi, 3 spill
    int          m_st = 0;
    bit          m_bv = 0;
    logic [NC-1:0] m_tlo = '0, m_thi = '0, m_stat = '0;
    bit          m_evt = 0;
    int          m_id = 0;

    always #5 clk = ~clk;

    iac_tagger #(.ADDR_W(AW), .NUM_CMP(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .flush(flush), .dec_is32(dec_is32), .dec_block(dec_block),
        .cmp_addr(cmp_addr), .cmp_en(cmp_en), .stat_clr(stat_clr), .tag_valid(tag_valid),
        .tag_lo(tag_lo), .tag_hi(tag_hi), .evt_valid(evt_valid), .evt_id(evt_id),
        .evt_status(evt_status)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R1 model: halfword match with comparator bit 0 ignored
    function automatic logic [NC-1:0] tags_of(input logic [AW-1:1] a, input bit hi);
        logic [NC-1:0] t;
        logic [AW-1:1] hw;
        hw = {a[AW-1:2], hi};
        for (int i = 0; i < NC; i++) t[i] = (hw == cmp_addr[i*AW+1 +: AW-1]);
        return t;
    endfunction

    task automatic drive(input bit fv, input logic [31:0] byte_addr, input bit is32,
                         input bit blk, input bit fl, input logic [NC-1:0] en,
                         input logic [NC-1:0] clr);
        fetch_valid = fv; fetch_addr = byte_addr[AW-1:1]; dec_is32 = is32;
        dec_block = blk; flush = fl; cmp_en = en; stat_clr = clr;
    endtask

    task automatic step(input string nm);
        bit iss, cons, rdy, ld;
        logic [NC-1:0] st_tag, hits;
        int nx;
        #1;
        iss  = m_bv && (m_st == 1 || m_st == 2) && !flush && !dec_block;
        cons = iss && (m_st == 2 || dec_is32);
        rdy  = !m_bv || cons;
        ld   = fetch_valid && rdy;
        chk("R11", {63'd0, fetch_ready}, {63'd0, rdy});
        st_tag = (m_st == 2) ? m_thi : m_tlo;
        hits = st_tag & cmp_en;
        nx = m_st;
        if (m_st == 0 && ld) nx = fetch_addr[1] ? 2 : 1;
        else if (m_st == 1 && iss) nx = dec_is32 ? 1 : 2;
        else if (m_st == 2 && iss) nx = dec_is32 ? 3 : 2 - 1;
        else if (m_st == 3 && m_bv) nx = 2;
        @(posedge clk);
        m_evt = iss && (|hits);
        if (m_evt) m_id = hits[0] ? 0 : 1;
        m_stat = (m_stat & ~stat_clr) | (iss ? hits : '0);
        if (flush) begin
            m_bv = 0; nx = 0;
        end else if (ld) begin
            m_bv = 1; m_tlo = tags_of(fetch_addr, 1'b0); m_thi = tags_of(fetch_addr, 1'b1);
        end else if (cons) m_bv = 0;
        m_st = nx;
        #1;
        chk(flush ? "R9" : "R2", {63'd0, tag_valid}, {63'd0, m_bv});
        if (m_bv) begin
            chk("R1", {62'd0, tag_lo}, {62'd0, m_tlo});
            chk("R1", {62'd0, tag_hi}, {62'd0, m_thi});
        end
        chk(nm, {63'd0, evt_valid}, {63'd0, m_evt});
        if (m_evt) chk("R7", {63'd0, evt_id}, 64'(m_id));
        chk("R8", {62'd0, evt_status}, {62'd0, m_stat});
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        cmp_addr[0 +: AW]  = 32'h0000_1001;   // R1: bit 0 set, must still match 0x1000
        cmp_addr[AW +: AW] = 32'h0000_1006;
        repeat (3) @(negedge clk);
        #1;
        chk("R2", {63'd0, tag_valid}, 64'd0);
        chk("R2", {63'd0, evt_valid}, 64'd0);
        chk("R8", {62'd0, evt_status}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R10: word at 0x1000, start at low halfword
        drive(1, 32'h1000, 0, 0, 0, 2'b11, 0); step("R10");
        // R3: 16-bit at low halfword hits comparator 0
        drive(1, 32'h1004, 0, 0, 0, 2'b11, 0); step("R3");
        // high halfword 16-bit, consumes word, next word loads
        drive(1, 32'h1004, 0, 0, 0, 2'b11, 0); step("R3");
        // R4: 32-bit at 0x1004; tail 0x1006 hits comparator 1 only
        drive(0, 32'h0, 1, 0, 0, 2'b11, 0); step("R4");
        step("R4");
        // R4 across words: 32-bit starting at high halfword 0x1002, tail 0x1004
        drive(0, 32'h0, 0, 0, 1, 2'b11, 0); step("R9");
        drive(1, 32'h1002, 1, 0, 0, 2'b11, 0); step("R10");
        drive(1, 32'h1004, 1, 0, 0, 2'b11, 0); step("R4");
        drive(0, 32'h0, 0, 0, 0, 2'b11, 0); step("R4");
        // now at high halfword 0x1006: R5 block, then R6 disabled
        drive(0, 32'h0, 0, 1, 0, 2'b11, 0); step("R5");
        drive(0, 32'h0, 0, 0, 0, 2'b01, 0); step("R6");
        // R8: clear comparator 0 status
        drive(0, 32'h0, 0, 0, 0, 2'b11, 2'b01); step("R8");
        // R7: both comparators at 0x1000
        cmp_addr[AW +: AW] = 32'h0000_1000;
        drive(1, 32'h1000, 0, 0, 0, 2'b11, 0); step("R7");
        drive(0, 32'h0, 0, 0, 0, 2'b11, 2'b11); step("R7");
        // R9: flush with word buffered and offered
        drive(1, 32'h1000, 0, 0, 1, 2'b11, 0); step("R9");
        drive(0, 32'h0, 0, 0, 0, 2'b11, 0); step("R9");

        // seeded random traffic
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) begin
                cmp_addr[0 +: AW]  = 32'h0000_2000 + ($urandom % 16);
                cmp_addr[AW +: AW] = 32'h0000_2000 + ($urandom % 16);
            end
            drive(($urandom % 4) != 0, 32'h0000_2000 + (($urandom % 8) << 1),
                  $urandom % 2, ($urandom % 8) == 0, ($urandom % 32) == 0,
                  2'($urandom), (($urandom % 8) == 0) ? 2'($urandom) : 2'b00);
            step("R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule